// File: doc/BRIEF.md
# Reloadable Periodic Interval Timer

This block raises a level interrupt at a software-chosen rate derived from a 1 kHz base. Software writes a reload value `r`, and the timer then runs at `floor(1000 / (r + 1))` periods per second. A write clears any pending interrupt and restarts timing from the beginning. At the end of each period the interrupt goes high and the next period begins with no gap. Software acknowledges by reading the interval count register, which the block sees as a one-cycle read strobe; that read returns zero. A reload of 1000 or more gives a rate of zero, and the timer then stays stopped until the next write.

The rate is found by a bit-serial divider, one quotient bit per clock. Time is kept by a phase accumulator that adds the rate on every clock and wraps at the system clock frequency `CLK_HZ`. A period therefore ends on each edge where `floor(n * rate / CLK_HZ)` steps up, where n counts accumulating edges. This gives an average rate that is exact even when `CLK_HZ / rate` is not an integer.

The controller has three states. `ST_RUN` accumulates phase. `ST_DIVIDE` computes the rate, and `ST_STOP` idles with a zero rate. The transitions are:

- Any state goes to `ST_DIVIDE` on a reload write ("restart").
- `ST_DIVIDE` goes to `ST_RUN` on the final divider step when the quotient is non-zero ("rate ready").
- `ST_DIVIDE` goes to `ST_STOP` on the final divider step when the quotient is zero ("rate zero").
- `ST_RUN` and `ST_STOP` otherwise hold.

Reset enters `ST_RUN` with the rate of a zero reload.

Top module: `interval_timer`

## Requirements
- R1: After reset `irq` is low. The timer runs at the rate of reload 0 (1000 per second), and the first edge after reset release is accumulating edge n=1.
- R2: While running, a period ends on accumulating edge n exactly when `floor(n*rate/CLK_HZ) > floor((n-1)*rate/CLK_HZ)`, with `rate = floor(1000/(reload+1))`. On all other edges `irq` does not rise.
- R3: A write (`wr_reload` high at edge E) makes `irq` low after E. The rate is computed over edges E+1 to E+10, and accumulation restarts from zero phase with n=1 at edge E+11.
- R4: At a period end `irq` is high after that edge. The phase remainder is carried, so the next period starts at once.
- R5: `rd_count` high at an edge with no period end and no write makes `irq` low after it.
- R6: When a read strobe and a period end fall on the same edge, `irq` is high after it.
- R7: When a write and a would-be period end fall on the same edge, the write wins: `irq` is low after it and timing restarts as in R3.
- R8: A reload of 1000 or more gives rate 0. The timer is stopped and `irq` stays low until the next write.
- R9: A write that arrives during rate computation restarts it. Latency counts from the latest write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `CLK_HZ` cycles per second |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_reload | input | 1 | Reload register write strobe |
| reload_in | input | RELOAD_W | Reload value written with `wr_reload` |
| rd_count | input | 1 | Interval count register read strobe (acknowledge) |
| irq | output | 1 | Timer interrupt level |

## Verification
Two pairs of events can fall on one clock edge. The first pair is a period end and an acknowledge read. The second pair is a period end and a reload write. The bench provokes the first pair by issuing read strobes on a fixed cycle pattern, and also continuously, at short periods, so that reads land on period-end edges. It provokes the second pair by timing a write to the exact edge where a period would have ended. For every edge, an arithmetic model of the rate and phase predicts `irq`. A collision is judged by requiring `irq` high after a read that coincides with a period end, and low after a write that coincides with a period end.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    typedef enum logic [1:0] {
        ST_STOP   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_RUN    = 2'd2
    } ivt_state_e;
endpackage

// File: rtl/ivt_rate_div.sv
// Bit-serial restoring divider: BASE_RATE / (reload + 1), one quotient bit per cycle.
module ivt_rate_div #(
    parameter int RELOAD_W  = 16,
    parameter int BASE_RATE = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [RELOAD_W-1:0] reload,
    output logic                last,
    output logic [$clog2(BASE_RATE+1)-1:0] quot_next
);
    localparam int Q_W   = $clog2(BASE_RATE + 1);
    localparam int IDX_W = (Q_W > 1) ? $clog2(Q_W) : 1;
    localparam int DV_W  = RELOAD_W + 1;
    localparam int SH_W  = RELOAD_W + 2;
    localparam logic [Q_W-1:0] DIVIDEND = Q_W'(BASE_RATE);

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic [DV_W-1:0]  rem_q;
    logic [DV_W-1:0]  dvs_q;
    logic [Q_W-1:0]   quot_q;

    logic [SH_W-1:0]  rem_sh;
    logic             ge;
    logic [DV_W-1:0]  rem_n;

    always_comb begin
        rem_sh    = {rem_q, DIVIDEND[idx_q]};
        ge        = (rem_sh >= {1'b0, dvs_q});
        rem_n     = ge ? DV_W'(rem_sh - {1'b0, dvs_q}) : rem_sh[DV_W-1:0];
        quot_next = {quot_q[Q_W-2:0], ge};
        last      = busy_q && (idx_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            rem_q  <= '0;
            dvs_q  <= DV_W'(1);
            quot_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            idx_q  <= IDX_W'(Q_W - 1);
            rem_q  <= '0;
            dvs_q  <= {1'b0, reload} + DV_W'(1);
            quot_q <= '0;
        end else if (busy_q) begin
            rem_q  <= rem_n;
            quot_q <= quot_next;
            idx_q  <= idx_q - IDX_W'(1);
            if (idx_q == '0) busy_q <= 1'b0;
        end
    end

    // Partial remainder always stays below the divisor (R2 rate correctness).
    assert_rem_below_divisor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (rem_q < dvs_q));

    // Step index never leaves the quotient width (R3 fixed latency).
    assert_step_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (idx_q <= IDX_W'(Q_W - 1)));
endmodule

// File: rtl/ivt_phase_acc.sv
// Phase accumulator: adds the rate each enabled cycle, wraps at CLK_HZ.
module ivt_phase_acc #(
    parameter int CLK_HZ = 50_000_000,
    parameter int Q_W    = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           en,
    input  logic [Q_W-1:0] rate,
    output logic           fire
);
    localparam int ACC_W = $clog2(CLK_HZ + (1 << Q_W)) + 1;
    localparam logic [ACC_W-1:0] WRAP = ACC_W'(CLK_HZ);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        sum  = acc_q + ACC_W'(rate);
        fire = en && (sum >= WRAP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q <= '0;
        else if (clr)    acc_q <= '0;
        else if (en)     acc_q <= fire ? (sum - WRAP) : sum;
    end

    // Remainder is carried below one second's worth of clocks (R4).
    assert_phase_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < WRAP);
endmodule

// File: rtl/ivt_irq_ctrl.sv
// Interrupt level: restart clears, period end sets, read acknowledge clears.
module ivt_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic period_end,
    input  logic ack,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          irq <= 1'b0;
        else if (restart)    irq <= 1'b0;
        else if (period_end) irq <= 1'b1;
        else if (ack)        irq <= 1'b0;
    end

    assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !irq);

    assert_end_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && !restart) |=> irq);

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !period_end && !restart) |=> !irq);

    assert_rise_only_on_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(period_end));
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int CLK_HZ    = 50_000_000,
    parameter int RELOAD_W  = 16,
    parameter int BASE_RATE = 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_reload,
    input  logic [RELOAD_W-1:0] reload_in,
    input  logic                rd_count,
    output logic                irq
);
    import ivt_pkg::*;

    localparam int Q_W = $clog2(BASE_RATE + 1);

    ivt_state_e      state_q, state_d;
    logic [Q_W-1:0]  rate_q;
    logic            div_last;
    logic [Q_W-1:0]  div_quot;
    logic            acc_en, acc_clr, period_end;

    ivt_rate_div #(.RELOAD_W(RELOAD_W), .BASE_RATE(BASE_RATE)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (wr_reload),
        .reload    (reload_in),
        .last      (div_last),
        .quot_next (div_quot)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            rate_q  <= Q_W'(BASE_RATE);
        end else begin
            state_q <= state_d;
            if (!wr_reload && div_last && state_q == ST_DIVIDE) rate_q <= div_quot;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        acc_en  = 1'b0;
        acc_clr = wr_reload;
        unique case (state_q)
            ST_RUN: begin
                acc_en = 1'b1;
            end
            ST_DIVIDE: begin
                if (div_last) begin
                    acc_clr = 1'b1;
                    state_d = (div_quot == '0) ? ST_STOP : ST_RUN;
                end
            end
            ST_STOP: begin
                state_d = ST_STOP;
            end
            default: state_d = ST_STOP;
        endcase
        if (wr_reload) state_d = ST_DIVIDE;
    end

    ivt_phase_acc #(.CLK_HZ(CLK_HZ), .Q_W(Q_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .en    (acc_en),
        .rate  (rate_q),
        .fire  (period_end)
    );

    ivt_irq_ctrl u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (wr_reload),
        .period_end (period_end),
        .ack        (rd_count),
        .irq        (irq)
    );

    assert_stopped_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |-> !irq);

    assert_rewrite_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reload |=> (state_q == ST_DIVIDE));

    assert_no_end_while_dividing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIVIDE) |-> !period_end);

    assert_running_rate_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (rate_q != '0));
endmodule

// File: tb/interval_timer_bench.sv
`timescale 1ns/1ps
module interval_timer_bench;
    localparam int F   = 4000;
    localparam int RW  = 16;
    localparam int LAT = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_reload = 1'b0;
    logic [RW-1:0] reload_in = '0;
    logic          rd_count = 1'b0;
    logic          irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    int  d_m;
    int  rate_m;
    bit  irq_m;

    always #2 clk = ~clk;

    interval_timer #(.CLK_HZ(F), .RELOAD_W(RW), .BASE_RATE(1000)) u_interval_timer (
        .clk(clk), .rst_n(rst_n), .wr_reload(wr_reload),
        .reload_in(reload_in), .rd_count(rd_count), .irq(irq)
    );

    task automatic check(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s irq actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, model the edge, compare at the following negedge.
    task automatic step(input bit wr, input int val, input bit ack, input string tag);
        bit     fire;
        int     dn;
        longint n;
        string  t;
        wr_reload = wr;
        reload_in = RW'(val);
        rd_count  = ack;
        @(posedge clk);
        dn   = d_m + 1;
        fire = 1'b0;
        if (dn > LAT && rate_m > 0) begin
            n    = longint'(dn - LAT);
            fire = ((n * rate_m) / F) != (((n - 1) * rate_m) / F);
        end
        t = tag;
        if (wr) begin
            if (t == "") t = fire ? "R7" : "R3";
            irq_m  = 1'b0;
            d_m    = 0;
            rate_m = 1000 / (val + 1);
        end else begin
            d_m = dn;
            if (t == "") t = (fire && ack) ? "R6" : fire ? "R4" : ack ? "R5" :
                             (rate_m == 0) ? "R8" : "R2";
            if (fire)     irq_m = 1'b1;
            else if (ack) irq_m = 1'b0;
        end
        @(negedge clk);
        wr_reload = 1'b0;
        rd_count  = 1'b0;
        check(irq, irq_m, t);
    endtask

    task automatic run_reload(input int val, input int ack_mod);
        int len;
        int rate = 1000 / (val + 1);
        len = (rate > 0) ? (3 * F / rate + LAT + 20) : 400;
        step(1'b1, val, 1'b0, "");
        for (int i = 0; i < len; i++)
            step(1'b0, 0, (ack_mod > 0) && (i % ack_mod == 2), "");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(irq, 1'b0, "R1");
        rst_n  = 1'b1;
        d_m    = LAT;
        rate_m = 1000;
        irq_m  = 1'b0;
        for (int i = 0; i < 40; i++) step(1'b0, 0, 1'b0, "R1");

        // Sweep of small reloads with a periodic acknowledge pattern (R2, R4, R5, R6)
        for (int r = 0; r <= 12; r++) run_reload(r, 5);
        run_reload(99, 7);
        run_reload(499, 11);
        run_reload(999, 13);
        run_reload(3, 0);

        // Acknowledge held every cycle at the fastest rate (R6 collisions)
        step(1'b1, 0, 1'b0, "");
        for (int i = 0; i < 40; i++) step(1'b0, 0, 1'b1, "");

        // Write landing on a period-end edge (R7): fire at edge LAT+4 after a write of 0
        step(1'b1, 0, 1'b0, "");
        for (int i = 0; i < LAT + 3; i++) step(1'b0, 0, 1'b0, "");
        step(1'b1, 1, 1'b0, "R7");
        for (int i = 0; i < 40; i++) step(1'b0, 0, 1'b0, "");

        // Rewrite during rate computation (R9)
        step(1'b1, 3, 1'b0, "R9");
        for (int i = 0; i < 5; i++) step(1'b0, 0, 1'b0, "R9");
        step(1'b1, 1, 1'b0, "R9");
        for (int i = 0; i < 60; i++) step(1'b0, 0, 1'b0, "R9");

        // Stopped rates (R8), then recovery by a new write
        run_reload(1000, 0);
        run_reload(65535, 9);
        run_reload(1001, 0);
        run_reload(2, 4);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule